// File: doc/BRIEF.md
# Host Bus Pointer and Register Interface

This block is a slave on a 16-bit parallel host bus. The host starts each access with a rising edge on its request line. The block captures the cycle type, the address and the write data in that same edge. The access then runs in one of three classes. The first class loads or reads one of two 22-bit memory pointers, in a low 16-bit half and a high 6-bit half. The second class writes or reads one of four 16-bit control registers. The third class moves a single word between the bus and an external word memory at the selected pointer, with an optional post-increment.

When an access finishes, a one-clock ready pulse tells the host that read data is valid or that the write has landed. The last control register is not storage. A write to it issues a command word to the sequencer. A read from it returns a status word built from this block's own bus state and the state codes of the memory controller and the sequencer. While the sequencer reports busy, memory accesses are refused and register traffic goes on as normal. A clear input returns the pointers and the bus state machine to their idle values and releases the serial converter pins.

Top module: `hbus_host_if`

## Requirements
- R1: After reset, bus_ready, mem_req and cmd_strobe are 0, bus_dout and ctrl_regs are all zero, and both pointers read as 0.
- R2: A cycle with bus_cmd_n=0 and bus_dac=0 accesses a pointer. bus_addr[1] selects pointer 0 or 1. bus_addr[0]=0 accesses pointer bits 15..0 on bus bits 15..0. bus_addr[0]=1 accesses pointer bits 21..16 on bus bits 5..0, and a read returns 0 on bus bits 15..6. bus_rd_n=1 writes and bus_rd_n=0 reads.
- R3: A cycle with bus_cmd_n=0 and bus_dac=1 accesses control register bus_addr. Writes to registers 0..2 are stored, read back unchanged and appear on ctrl_regs, with register k in bits 16k+15..16k.
- R4: A write to register 3 puts the bus word on cmd_word and pulses cmd_strobe for exactly one clock. A read of register 3 returns seq_state in bits 11..8, memc_state in bits 6..4 and this block's own state code in bits 2..0, with zeros elsewhere. That state code is 2 during a register read.
- R5: A cycle with bus_cmd_n=1 accesses memory at the pointer chosen by bus_addr[1]. It writes the captured bus word when bus_rd_n=1 and returns the memory word when bus_rd_n=0. mem_addr stays steady until mem_ack. With bus_addr[0]=0 the pointer is not changed.
- R6: With bus_addr[0]=1, a memory access increments the selected pointer by one after the access. The pointer wraps from 0x3FFFFF to 0.
- R7: While seq_busy is 1 at the start of a memory access, the access is refused. mem_req stays low, a read returns 0x0000, a write is discarded, the pointer is not incremented, and bus_ready still pulses.
- R8: Each rising edge of bus_req gives exactly one access and exactly one single-clock bus_ready pulse. Holding bus_req high starts no further access.
- R9: While bus_fclr is 1, out_hiz is 1. bus_fclr clears both pointers, returns the bus state machine to idle and drops mem_req and bus_ready, whatever the other inputs are.
- R10: bus_dout_en is 1 exactly while bus_req=1, bus_rd_n=0 and bus_fclr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_fclr | input | 1 | Clear of pointers and state machines |
| bus_req | input | 1 | Access request; a rising edge starts an access |
| bus_cmd_n | input | 1 | 0: pointer or register cycle, 1: memory cycle |
| bus_rd_n | input | 1 | 0: read, 1: write |
| bus_dac | input | 1 | In a cycle with bus_cmd_n=0, selects a control register instead of a pointer |
| bus_addr | input | 2 | Cycle address |
| bus_din | input | 16 | Write data from the host |
| bus_dout | output | 16 | Read data to the host |
| bus_dout_en | output | 1 | Drive enable for the host data bus |
| bus_ready | output | 1 | One-clock access-complete pulse |
| out_hiz | output | 1 | Releases the converter serial pins |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | 22 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge pulse |
| seq_busy | input | 1 | Sequencer running |
| memc_state | input | 3 | Memory controller state code |
| seq_state | input | 4 | Sequencer state code |
| ctrl_regs | output | 48 | Control registers 0..2 |
| cmd_word | output | 16 | Last word written to register 3 |
| cmd_strobe | output | 1 | One-clock pulse after a register 3 write |

## Verification
The properties assume that mem_ack comes only while mem_req is high, as a single-clock pulse, and that the host does not raise a new request before the ready pulse of the previous one. They also assume that seq_busy does not change in the clock where a memory access is decided. The bench meets these assumptions by construction. Its memory model acknowledges each request after a fixed latency and then lets the acknowledge fall. Every bus access waits for ready and drops the request before the next one starts. seq_busy changes only between accesses.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_PTR = 2;
  localparam int unsigned NUM_CR  = 4;
  localparam int unsigned PSEL_W  = $clog2(NUM_PTR);
  localparam int unsigned CSEL_W  = $clog2(NUM_CR);
  localparam int unsigned HST_W   = 3;
  localparam int unsigned MST_W   = 3;
  localparam int unsigned SST_W   = 4;

  // Codes are visible in the status word; values are fixed.
  typedef enum logic [HST_W-1:0] {
    HS_IDLE   = 3'd0,
    HS_LATCH  = 3'd1,
    HS_RD_REG = 3'd2,
    HS_WR_REG = 3'd3,
    HS_RD_MEM = 3'd4,
    HS_WR_MEM = 3'd5,
    HS_DONE   = 3'd6
  } host_state_t;
endpackage

// File: rtl/hbus_ctrl_fsm.sv
module hbus_ctrl_fsm
  import hbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fclr,
  input  logic                  req,
  input  logic                  cmd_n,
  input  logic                  rd_n,
  input  logic                  dac,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     din,
  input  logic                  seq_busy,
  input  logic                  mem_ack,
  output host_state_t           state_o,
  output logic [ADDR_W-1:0]     lat_addr,
  output logic                  lat_dac,
  output logic [DATA_W-1:0]     lat_din,
  output logic                  reg_wr,
  output logic                  reg_rd,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic                  mem_done,
  output logic                  refuse_rd,
  output logic                  ready
);
  host_state_t state_q, state_d;
  logic        req_q;
  logic        lat_cmd_n_q, lat_rd_n_q, lat_dac_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_din_q;
  logic        req_rise, lat_en;

  assign req_rise = req & ~req_q;
  assign lat_en   = (state_q == HS_IDLE) & req_rise & ~fclr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:   if (req_rise) state_d = HS_LATCH;
      HS_LATCH: begin
        if (!lat_cmd_n_q)  state_d = lat_rd_n_q ? HS_WR_REG : HS_RD_REG;
        else if (seq_busy) state_d = HS_DONE;
        else               state_d = lat_rd_n_q ? HS_WR_MEM : HS_RD_MEM;
      end
      HS_RD_REG, HS_WR_REG: state_d = HS_DONE;
      HS_RD_MEM, HS_WR_MEM: if (mem_ack) state_d = HS_DONE;
      HS_DONE:   state_d = HS_IDLE;
      default:   state_d = HS_IDLE;
    endcase
    if (fclr) state_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cmd_n_q <= 1'b0;
      lat_rd_n_q  <= 1'b1;
      lat_dac_q   <= 1'b0;
      lat_addr_q  <= '0;
      lat_din_q   <= '0;
    end else if (lat_en) begin
      lat_cmd_n_q <= cmd_n;
      lat_rd_n_q  <= rd_n;
      lat_dac_q   <= dac;
      lat_addr_q  <= addr;
      lat_din_q   <= din;
    end
  end

  assign state_o   = state_q;
  assign lat_addr  = lat_addr_q;
  assign lat_dac   = lat_dac_q;
  assign lat_din   = lat_din_q;
  assign reg_wr    = (state_q == HS_WR_REG) & ~fclr;
  assign reg_rd    = (state_q == HS_RD_REG) & ~fclr;
  assign mem_req   = (state_q == HS_RD_MEM) | (state_q == HS_WR_MEM);
  assign mem_we    = (state_q == HS_WR_MEM);
  assign mem_done  = mem_req & mem_ack & ~fclr;
  assign refuse_rd = (state_q == HS_LATCH) & lat_cmd_n_q & ~lat_rd_n_q & seq_busy & ~fclr;
  assign ready     = (state_q == HS_DONE);
endmodule

// File: rtl/hbus_ptr_bank.sv
module hbus_ptr_bank
  import hbus_pkg::*;
#(
  parameter int unsigned PTR_W  = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fclr,
  input  logic [PSEL_W-1:0] sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              inc,
  input  logic [DATA_W-1:0] din,
  output logic [PTR_W-1:0]  sel_ptr
);
  localparam int unsigned HI_W = PTR_W - DATA_W;

  logic [NUM_PTR*PTR_W-1:0] ptr_all;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic             hit, en;
    logic [PTR_W-1:0] q, d;

    assign hit = (sel == PSEL_W'(g));
    assign en  = fclr | (hit & (wr_lo | wr_hi | inc));

    always_comb begin
      d = q;
      if (fclr)               d = '0;
      else if (hit && wr_lo)  d = {q[PTR_W-1:DATA_W], din};
      else if (hit && wr_hi)  d = {din[HI_W-1:0], q[DATA_W-1:0]};
      else if (hit && inc)    d = q + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign ptr_all[g*PTR_W +: PTR_W] = q;
  end

  assign sel_ptr = ptr_all[sel*PTR_W +: PTR_W];
endmodule

// File: rtl/hbus_creg_file.sv
module hbus_creg_file
  import hbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [CSEL_W-1:0]              sel,
  input  logic [DATA_W-1:0]              din,
  input  logic [HST_W-1:0]               host_st,
  input  logic [MST_W-1:0]               memc_st,
  input  logic [SST_W-1:0]               seq_st,
  output logic [(NUM_CR-1)*DATA_W-1:0]   cr_flat,
  output logic [DATA_W-1:0]              cmd_word,
  output logic                           cmd_strobe,
  output logic [DATA_W-1:0]              rd_val
);
  localparam int unsigned STAT_W = SST_W + 1 + MST_W + 1 + HST_W;
  localparam logic [CSEL_W-1:0] CMD_IDX = CSEL_W'(NUM_CR - 1);

  for (genvar g = 0; g < NUM_CR - 1; g++) begin : g_cr
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= '0;
      else if (wr && sel == CSEL_W'(g))   q <= din;
    end
    assign cr_flat[g*DATA_W +: DATA_W] = q;
  end

  logic [DATA_W-1:0] cmd_q;
  logic              stb_q;
  logic              cmd_hit;
  assign cmd_hit = wr & (sel == CMD_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_q <= '0;
    else if (cmd_hit) cmd_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= cmd_hit;
  end

  logic [DATA_W-1:0] status;
  assign status = {{(DATA_W-STAT_W){1'b0}}, seq_st, 1'b0, memc_st, 1'b0, host_st};

  always_comb begin
    rd_val = status;
    for (int i = 0; i < NUM_CR - 1; i++) begin
      if (sel == CSEL_W'(i)) rd_val = cr_flat[i*DATA_W +: DATA_W];
    end
  end

  assign cmd_word   = cmd_q;
  assign cmd_strobe = stb_q;
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
  import hbus_pkg::*;
#(
  parameter int unsigned PTR_W  = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_fclr,
  input  logic                          bus_req,
  input  logic                          bus_cmd_n,
  input  logic                          bus_rd_n,
  input  logic                          bus_dac,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_din,
  output logic [DATA_W-1:0]             bus_dout,
  output logic                          bus_dout_en,
  output logic                          bus_ready,
  output logic                          out_hiz,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [PTR_W-1:0]              mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata,
  input  logic                          mem_ack,
  input  logic                          seq_busy,
  input  logic [MST_W-1:0]              memc_state,
  input  logic [SST_W-1:0]              seq_state,
  output logic [(NUM_CR-1)*DATA_W-1:0]  ctrl_regs,
  output logic [DATA_W-1:0]             cmd_word,
  output logic                          cmd_strobe
);
  localparam int unsigned HI_W = PTR_W - DATA_W;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  host_state_t       host_st;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_dac;
  logic [DATA_W-1:0] lat_din;
  logic              reg_wr, reg_rd, mem_done, refuse_rd;

  hbus_ctrl_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .fclr(bus_fclr),
    .req(bus_req), .cmd_n(bus_cmd_n), .rd_n(bus_rd_n), .dac(bus_dac),
    .addr(bus_addr), .din(bus_din), .seq_busy(seq_busy), .mem_ack(mem_ack),
    .state_o(host_st), .lat_addr(lat_addr), .lat_dac(lat_dac), .lat_din(lat_din),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .mem_req(mem_req), .mem_we(mem_we),
    .mem_done(mem_done), .refuse_rd(refuse_rd), .ready(bus_ready)
  );

  // Pointer cycles: addr[1] picks the pointer, addr[0] the half.
  // Memory cycles: addr[1] picks the pointer, addr[0] asks for post-increment.
  logic ptr_wr, ptr_wr_lo, ptr_wr_hi, ptr_inc;
  logic [PTR_W-1:0] sel_ptr;
  assign ptr_wr    = reg_wr & ~lat_dac;
  assign ptr_wr_lo = ptr_wr & ~lat_addr[0];
  assign ptr_wr_hi = ptr_wr &  lat_addr[0];
  assign ptr_inc   = mem_done & lat_addr[0];

  hbus_ptr_bank #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .fclr(bus_fclr),
    .sel(lat_addr[ADDR_W-1 -: PSEL_W]), .wr_lo(ptr_wr_lo), .wr_hi(ptr_wr_hi),
    .inc(ptr_inc), .din(lat_din), .sel_ptr(sel_ptr)
  );

  logic [DATA_W-1:0] cr_rd;
  hbus_creg_file #(.DATA_W(DATA_W)) u_creg (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr & lat_dac), .sel(lat_addr[CSEL_W-1:0]),
    .din(lat_din), .host_st(host_st), .memc_st(memc_state), .seq_st(seq_state),
    .cr_flat(ctrl_regs), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe), .rd_val(cr_rd)
  );

  // Read data register
  logic [DATA_W-1:0] ptr_half, dout_d, dout_q;
  logic              dout_en;
  assign ptr_half = lat_addr[0] ? {{(DATA_W-HI_W){1'b0}}, sel_ptr[PTR_W-1:DATA_W]}
                                : sel_ptr[DATA_W-1:0];
  assign dout_en  = reg_rd | (mem_done & ~mem_we) | refuse_rd;

  always_comb begin
    dout_d = '0;
    if (reg_rd)        dout_d = lat_dac ? cr_rd : ptr_half;
    else if (mem_done) dout_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end

  assign bus_dout    = dout_q;
  assign bus_dout_en = bus_req & ~bus_rd_n & ~bus_fclr;
  assign out_hiz     = bus_fclr;
  assign mem_addr    = sel_ptr;
  assign mem_wdata   = lat_din;
endmodule

// File: rtl/hbus_if_chk.sv
module hbus_if_chk #(
  parameter int unsigned PTR_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fclr,
  input logic             seq_busy,
  input logic             ready,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [PTR_W-1:0] mem_addr,
  input logic             cmd_strobe
);
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_no_mem_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !$past(seq_busy));

  p_clear_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fclr |=> (!mem_req && !ready));

  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !fclr) |=> $stable(mem_addr));

  p_req_drops_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);
endmodule

bind hbus_host_if hbus_if_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .fclr(bus_fclr), .seq_busy(seq_busy),
  .ready(bus_ready), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .cmd_strobe(cmd_strobe)
);

// File: tb/hbus_host_if_tb_top.sv
module hbus_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_fclr = 1'b0, bus_req = 1'b0, bus_cmd_n = 1'b0, bus_rd_n = 1'b1, bus_dac = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_din = '0;
  logic [15:0] bus_dout;
  logic        bus_dout_en, bus_ready, out_hiz;
  logic        mem_req, mem_we, mem_ack;
  logic [21:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        seq_busy = 1'b0;
  logic [2:0]  memc_state = '0;
  logic [3:0]  seq_state = '0;
  logic [47:0] ctrl_regs;
  logic [15:0] cmd_word;
  logic        cmd_strobe;

  int n_chk = 0;
  int n_err = 0;
  int mem_ops = 0;
  int stb_cnt = 0;
  logic [21:0] last_addr;

  always #10 clk = ~clk;

  hbus_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_fclr(bus_fclr), .bus_req(bus_req),
    .bus_cmd_n(bus_cmd_n), .bus_rd_n(bus_rd_n), .bus_dac(bus_dac),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_ready(bus_ready), .out_hiz(out_hiz),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .seq_busy(seq_busy), .memc_state(memc_state), .seq_state(seq_state),
    .ctrl_regs(ctrl_regs), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe)
  );

  // Memory model: acknowledge two clocks after a request, then drop.
  logic [15:0] mem_m [16];
  logic        ack_q = 1'b0;
  int          lat_cnt = 0;
  logic [15:0] rdata_q = '0;
  assign mem_ack   = ack_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0; lat_cnt <= 0;
    end else if (mem_req && !ack_q) begin
      if (lat_cnt == 1) begin
        ack_q <= 1'b1; lat_cnt <= 0;
        if (mem_we) mem_m[mem_addr[3:0]] <= mem_wdata;
        else        rdata_q <= mem_m[mem_addr[3:0]];
        last_addr <= mem_addr;
        mem_ops <= mem_ops + 1;
      end else lat_cnt <= lat_cnt + 1;
    end else ack_q <= 1'b0;
  end

  always @(posedge clk) if (cmd_strobe) stb_cnt <= stb_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic cmd_n, input logic rd_n, input logic dac,
                      input logic [1:0] addr, input logic [15:0] din,
                      output logic [15:0] rdata, input int hold = 0);
    int ops0;
    bit got = 0;
    @(negedge clk);
    bus_cmd_n = cmd_n; bus_rd_n = rd_n; bus_dac = dac; bus_addr = addr; bus_din = din;
    bus_req = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bus_ready) begin got = 1; break; end
    end
    chk("R8 ready seen", 32'(got), 32'd1);
    rdata = bus_dout;
    @(negedge clk);
    chk("R8 ready one clock", 32'(bus_ready), 32'd0);
    ops0 = mem_ops;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8 no repeat ready", 32'(bus_ready), 32'd0);
    end
    if (hold > 0) chk("R8 no repeat access", 32'(mem_ops), 32'(ops0));
    bus_req = 1'b0; bus_rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ptr_set(input logic n, input logic [21:0] v);
    logic [15:0] d;
    xfer(1'b0, 1'b1, 1'b0, {n, 1'b0}, v[15:0], d);
    xfer(1'b0, 1'b1, 1'b0, {n, 1'b1}, {10'd0, v[21:16]}, d);
  endtask

  task automatic ptr_get(input logic n, output logic [21:0] v);
    logic [15:0] lo, hi;
    xfer(1'b0, 1'b0, 1'b0, {n, 1'b0}, 16'h0, lo);
    xfer(1'b0, 1'b0, 1'b0, {n, 1'b1}, 16'h0, hi);
    chk("R2 upper read bits 15..6 zero", 32'(hi[15:6]), 32'd0);
    v = {hi[5:0], lo};
  endtask

  task automatic t_reset();
    logic [21:0] p;
    chk("R1 ready", 32'(bus_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cmd_strobe", 32'(cmd_strobe), 0);
    chk("R1 dout", 32'(bus_dout), 0);
    chk("R1 ctrl_regs lo", ctrl_regs[31:0], 0);
    chk("R1 ctrl_regs hi", 32'(ctrl_regs[47:32]), 0);
    ptr_get(1'b0, p); chk("R1 ptr0", 32'(p), 0);
    ptr_get(1'b1, p); chk("R1 ptr1", 32'(p), 0);
  endtask

  task automatic t_ptr();
    logic [21:0] p;
    logic [15:0] d;
    ptr_set(1'b0, 22'h15_1234);
    ptr_set(1'b1, 22'h2B_CDEF);
    ptr_get(1'b0, p); chk("R2 ptr0", 32'(p), 32'h15_1234);
    ptr_get(1'b1, p); chk("R2 ptr1", 32'(p), 32'h2B_CDEF);
    xfer(1'b0, 1'b0, 1'b0, 2'b11, 16'h0, d);
    chk("R2 ptr1 upper half", 32'(d), 32'h002B);
  endtask

  task automatic t_creg();
    logic [15:0] d;
    xfer(1'b0, 1'b1, 1'b1, 2'd0, 16'h1111, d);
    xfer(1'b0, 1'b1, 1'b1, 2'd1, 16'hBEEF, d);
    xfer(1'b0, 1'b1, 1'b1, 2'd2, 16'h0F0F, d);
    xfer(1'b0, 1'b0, 1'b1, 2'd1, 16'h0, d); chk("R3 read cr1", 32'(d), 32'hBEEF);
    xfer(1'b0, 1'b0, 1'b1, 2'd2, 16'h0, d); chk("R3 read cr2", 32'(d), 32'h0F0F);
    chk("R3 ctrl_regs", 32'(ctrl_regs[47:16]), 32'h0F0F_BEEF);
    chk("R3 ctrl_regs cr0", 32'(ctrl_regs[15:0]), 32'h1111);
  endtask

  task automatic t_cmd_status();
    logic [15:0] d;
    int s0 = stb_cnt;
    memc_state = 3'd5; seq_state = 4'hC;
    xfer(1'b0, 1'b1, 1'b1, 2'd3, 16'h0002, d);
    chk("R4 one strobe", 32'(stb_cnt - s0), 1);
    chk("R4 cmd_word", 32'(cmd_word), 32'h0002);
    xfer(1'b0, 1'b0, 1'b1, 2'd3, 16'h0, d);
    chk("R4 status word", 32'(d), 32'h0C52);
    chk("R4 cr0 untouched", 32'(ctrl_regs[15:0]), 32'h1111);
  endtask

  task automatic t_mem();
    logic [15:0] d;
    logic [21:0] p;
    ptr_set(1'b1, 22'h5);
    xfer(1'b1, 1'b1, 1'b0, 2'b10, 16'h1234, d);
    chk("R5 write address", 32'(last_addr), 5);
    ptr_get(1'b1, p); chk("R5 no increment", 32'(p), 5);
    xfer(1'b1, 1'b0, 1'b0, 2'b10, 16'h0, d);
    chk("R5 read data", 32'(d), 32'h1234);
  endtask

  task automatic t_inc();
    logic [15:0] d;
    logic [21:0] p;
    ptr_set(1'b0, 22'h8);
    xfer(1'b1, 1'b1, 1'b0, 2'b01, 16'hA001, d);
    xfer(1'b1, 1'b1, 1'b0, 2'b01, 16'hA002, d);
    ptr_get(1'b0, p); chk("R6 incremented twice", 32'(p), 10);
    ptr_set(1'b0, 22'h8);
    xfer(1'b1, 1'b0, 1'b0, 2'b01, 16'h0, d); chk("R6 read first", 32'(d), 32'hA001);
    xfer(1'b1, 1'b0, 1'b0, 2'b01, 16'h0, d); chk("R6 read second", 32'(d), 32'hA002);
    ptr_set(1'b0, 22'h3F_FFFF);
    xfer(1'b1, 1'b1, 1'b0, 2'b01, 16'hCAFE, d);
    chk("R6 top address used", 32'(last_addr), 32'h3F_FFFF);
    ptr_get(1'b0, p); chk("R6 wrap to zero", 32'(p), 0);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    logic [21:0] p;
    int ops0;
    ptr_set(1'b1, 22'h5);
    seq_busy = 1'b1;
    ops0 = mem_ops;
    xfer(1'b1, 1'b1, 1'b0, 2'b11, 16'hDEAD, d);
    xfer(1'b1, 1'b0, 1'b0, 2'b11, 16'h0, d);
    chk("R7 refused read returns zero", 32'(d), 0);
    chk("R7 no memory traffic", 32'(mem_ops), 32'(ops0));
    ptr_get(1'b1, p); chk("R7 pointer held, register read allowed", 32'(p), 5);
    seq_busy = 1'b0;
    xfer(1'b1, 1'b0, 1'b0, 2'b10, 16'h0, d);
    chk("R7 write discarded", 32'(d), 32'h1234);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    int ops0 = mem_ops;
    xfer(1'b1, 1'b1, 1'b0, 2'b10, 16'h7777, d, 6);
    chk("R8 held req gives one access", 32'(mem_ops - ops0), 1);
  endtask

  task automatic t_fclr();
    logic [21:0] p;
    ptr_set(1'b0, 22'h12_3456);
    ptr_set(1'b1, 22'h0A_BCDE);
    @(negedge clk);
    bus_fclr = 1'b1;
    @(negedge clk);
    chk("R9 out_hiz high", 32'(out_hiz), 1);
    chk("R9 ready low", 32'(bus_ready), 0);
    @(negedge clk);
    bus_fclr = 1'b0;
    @(negedge clk);
    chk("R9 out_hiz released", 32'(out_hiz), 0);
    ptr_get(1'b0, p); chk("R9 ptr0 cleared", 32'(p), 0);
    ptr_get(1'b1, p); chk("R9 ptr1 cleared", 32'(p), 0);
  endtask

  task automatic t_dout_en();
    @(negedge clk);
    chk("R10 idle no drive", 32'(bus_dout_en), 0);
    bus_cmd_n = 1'b0; bus_dac = 1'b1; bus_addr = 2'd0; bus_rd_n = 1'b0; bus_req = 1'b1;
    #1;
    chk("R10 drive on read", 32'(bus_dout_en), 1);
    bus_fclr = 1'b1;
    #1;
    chk("R10 clear stops drive", 32'(bus_dout_en), 0);
    @(negedge clk);
    bus_req = 1'b0; bus_rd_n = 1'b1;
    @(negedge clk);
    bus_fclr = 1'b0;
    @(negedge clk);
    chk("R9 aborted access leaves idle", 32'(mem_req | bus_ready), 0);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ptr();
    t_creg();
    t_cmd_status();
    t_mem();
    t_inc();
    t_busy();
    t_hold();
    t_fclr();
    t_dout_en();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule